// File: doc/BRIEF.md
# Masked Burst Address Counter

This block produces the address for one port of a memory during sequential (burst) accesses. A start address is loaded once. After that, each enabled clock steps the address forward. A mask register chooses which address bits take part in the count. Bits outside the mask keep their value, so a burst can run around inside an aligned window, or over a scattered set of bit positions, while the rest of the address stays fixed.

A mirror register keeps the most recent start address. A retransmit command restarts the burst from that address. When the counted field is already all ones and another step is asked for, a wrap-mode input picks the next value: either the counted bits fall back to zero, or the whole counter is reloaded from the mirror. An active-low flag goes low when a step brings the counted field to all ones. This warns the port that the next step will wrap.

All commands are sampled on the rising clock edge, and each takes effect on that edge. The address output and the flag come straight from registers.

Top module: `burst_addr_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the edge sets the address to 0, the mask to all ones and the mirror to 0, and drives `cnt_irq_n` high.
- R2: `cnt_clr` high outranks every other command. It sets the address to 0 and the mask to all ones, and drives `cnt_irq_n` high. The mirror keeps its value.
- R3: `ld_stb` high with `msk_sel` low, and no clear, copies `addr_in` into both the address and the mirror. It drives `cnt_irq_n` high.
- R4: `ld_stb` high with `msk_sel` high, and no clear, copies `addr_in` into the mask. The address and the mirror keep their values, and `cnt_irq_n` goes high.
- R5: `retx` high, with no clear and no load, copies the mirror into the address. `cnt_irq_n` keeps its value.
- R6: `cnt_en` high, with no clear, load or retransmit, steps the counter. The bits under mask ones are treated as one binary number, least significant position first, and incremented. The carry skips over bits where the mask is 0, and those bits keep their value.
- R7: If the masked bits are all ones before a step and `wrap_reload` is low, the step clears the masked bits and leaves the other bits unchanged. With a mask of all zeros, every step counts as this terminal case.
- R8: If the masked bits are all ones before a step and `wrap_reload` is high, the step copies the mirror into the address.
- R9: `cnt_irq_n` goes low on the edge of a step that is not terminal and leaves the masked bits all ones. It goes high on the edge of the next clear, load (of either kind) or step. Otherwise it keeps its value.
- R10: If no command is active, the address and `cnt_irq_n` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W (18) | Start address or mask value to be loaded |
| ld_stb | input | 1 | Load strobe, active high |
| cnt_en | input | 1 | Count enable, active high |
| cnt_clr | input | 1 | Counter clear, active high |
| msk_sel | input | 1 | Sends a load to the mask register instead of the counter |
| wrap_reload | input | 1 | Terminal step action: 0 clears the masked bits, 1 reloads from the mirror |
| retx | input | 1 | Retransmit: restart from the mirror |
| addr_out | output | ADDR_W (18) | Current address |
| cnt_irq_n | output | 1 | Active-low flag: the masked field has just reached all ones |

## Verification
The assertions assume that every command input has a known level at each edge once reset is released. They also assume that several commands may be active together, with the fixed priority order deciding which one takes effect. The stimulus never leaves a control input undefined. It often asserts more than one command in the same cycle, so that the priority order is exercised, and it uses masks of every kind: full, empty, contiguous low fields and random scattered patterns. The reference model works on the address field by packing the masked bits into an integer and unpacking them again, so it does not depend on the carry chain used in the design.

// File: rtl/burst_cnt_pkg.sv
// Package: shared command encoding for the masked burst address counter.
// Assumes: used by all modules of the counter; no parameters live here.
package burst_cnt_pkg;

    // One decoded command per clock, in priority order of the decoder.
    typedef enum logic [2:0] {
        CMD_HOLD     = 3'd0,
        CMD_CLEAR    = 3'd1,
        CMD_LOAD_CNT = 3'd2,
        CMD_LOAD_MSK = 3'd3,
        CMD_RETX     = 3'd4,
        CMD_STEP     = 3'd5
    } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_dec.sv
// Module: burst_cmd_dec
// Turns the raw control inputs into one command per cycle.
// Priority: clear, then load (counter or mask), then retransmit, then step.
// Assumes: inputs are already synchronous to the counter clock.
module burst_cmd_dec
    import burst_cnt_pkg::*;
(
    input  logic       ld_stb,
    input  logic       cnt_en,
    input  logic       cnt_clr,
    input  logic       msk_sel,
    input  logic       retx,
    output burst_cmd_e cmd
);

    // Purpose: fixed priority selection of the active command.
    always_comb begin
        if (cnt_clr) begin
            cmd = CMD_CLEAR;
        end else if (ld_stb) begin
            cmd = msk_sel ? CMD_LOAD_MSK : CMD_LOAD_CNT;
        end else if (retx) begin
            cmd = CMD_RETX;
        end else if (cnt_en) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // Exactly one command is chosen, and clear always wins (R2).
    always_comb begin
        if (cnt_clr) begin
            a_clear_wins_r2: assert (cmd == CMD_CLEAR)
                else $error("clear did not take priority");
        end
    end

endmodule

// File: rtl/burst_incr.sv
// Module: burst_incr
// Masked incrementer. Bits under mask ones form one binary number; the carry
// skips over bits where the mask is zero, and those bits pass through unchanged.
// at_top: the masked field is all ones (the next step is terminal).
// hits_top: a non-terminal step would leave the masked field all ones.
// Assumes: purely combinational; the caller decides whether to use the result.
module burst_incr #(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] nxt,
    output logic              at_top,
    output logic              hits_top
);

    logic [ADDR_W:0] carry;

    assign carry[0] = 1'b1;

    // Purpose: one ripple stage per address bit; masked-off bits pass carry.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign carry[b+1] = carry[b] & (cur[b] | ~mask[b]);
        assign nxt[b]     = mask[b] ? (cur[b] ^ carry[b]) : cur[b];
    end

    // Purpose: carry out of the top means every counted bit was one.
    assign at_top   = carry[ADDR_W];
    assign hits_top = ~at_top && ((nxt & mask) == mask);

    // Masked-off bits never change through the incrementer (R6).
    always_comb begin
        a_keep_fixed_r6: assert (((nxt ^ cur) & ~mask) == '0)
            else $error("masked-off bit altered by increment");
    end

endmodule

// File: rtl/burst_irq.sv
// Module: burst_irq
// Holds the active-low terminal-count flag. It is set by a non-terminal step
// that lands on an all-ones field. It is released by clear, either load, or
// any other step. Retransmit and idle cycles leave it alone.
// Assumes: cmd comes from burst_cmd_dec, hits_top from burst_incr.
module burst_irq
    import burst_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  burst_cmd_e cmd,
    input  logic       hits_top,
    output logic       irq_n
);

    logic flag_q;

    // Purpose: update the flag from the command of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_CLEAR, CMD_LOAD_CNT, CMD_LOAD_MSK: flag_q <= 1'b0;
                CMD_STEP:                              flag_q <= hits_top;
                default:                               flag_q <= flag_q;
            endcase
        end
    end

    assign irq_n = ~flag_q;

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && hits_top) |=> !irq_n);

    p_flag_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd inside {CMD_CLEAR, CMD_LOAD_CNT, CMD_LOAD_MSK}) |=> irq_n);

    p_flag_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd inside {CMD_RETX, CMD_HOLD}) |=> $stable(irq_n));

endmodule

// File: rtl/burst_addr_counter.sv
// Module: burst_addr_counter (top)
// Per-port burst address generator with a count mask, a mirror of the last
// start address, wrap-or-reload at terminal count, and an active-low flag
// when the counted field reaches all ones.
// Assumes: synchronous active-low reset; all control inputs are sampled on
// the rising edge of clk.
module burst_addr_counter
    import burst_cnt_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ld_stb,
    input  logic              cnt_en,
    input  logic              cnt_clr,
    input  logic              msk_sel,
    input  logic              wrap_reload,
    input  logic              retx,
    output logic [ADDR_W-1:0] addr_out,
    output logic              cnt_irq_n
);

    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ALL_ZERO = {ADDR_W{1'b0}};

    burst_cmd_e        cmd;
    logic [ADDR_W-1:0] cnt_q;
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] mirror_q;
    logic [ADDR_W-1:0] inc_val;
    logic [ADDR_W-1:0] cnt_d;
    logic              at_top;
    logic              hits_top;

    burst_cmd_dec i_dec (
        .ld_stb  (ld_stb),
        .cnt_en  (cnt_en),
        .cnt_clr (cnt_clr),
        .msk_sel (msk_sel),
        .retx    (retx),
        .cmd     (cmd)
    );

    burst_incr #(.ADDR_W(ADDR_W)) i_incr (
        .cur      (cnt_q),
        .mask     (mask_q),
        .nxt      (inc_val),
        .at_top   (at_top),
        .hits_top (hits_top)
    );

    burst_irq i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .hits_top (hits_top),
        .irq_n    (cnt_irq_n)
    );

    // Purpose: choose the next counter value from the decoded command.
    always_comb begin
        unique case (cmd)
            CMD_CLEAR:    cnt_d = ALL_ZERO;
            CMD_LOAD_CNT: cnt_d = addr_in;
            CMD_RETX:     cnt_d = mirror_q;
            CMD_STEP: begin
                if (!at_top)          cnt_d = inc_val;
                else if (wrap_reload) cnt_d = mirror_q;
                else                  cnt_d = cnt_q & ~mask_q;
            end
            default:      cnt_d = cnt_q;
        endcase
    end

    // Purpose: counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= ALL_ZERO;
        else        cnt_q <= cnt_d;
    end

    // Purpose: mask register; clear opens every bit, mask load replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mask_q <= ALL_ONES;
        else if (cmd == CMD_CLEAR)    mask_q <= ALL_ONES;
        else if (cmd == CMD_LOAD_MSK) mask_q <= addr_in;
    end

    // Purpose: mirror register; captures every counter load.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mirror_q <= ALL_ZERO;
        else if (cmd == CMD_LOAD_CNT) mirror_q <= addr_in;
    end

    assign addr_out = cnt_q;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (addr_out == ALL_ZERO && mask_q == ALL_ONES
                    && mirror_q == ALL_ZERO && cnt_irq_n));

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (addr_out == ALL_ZERO && mask_q == ALL_ONES
                     && $stable(mirror_q)));

    p_load_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && !cnt_clr && !msk_sel)
            |=> (addr_out == $past(addr_in) && mirror_q == $past(addr_in)));

    p_load_msk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && !cnt_clr && msk_sel)
            |=> ($stable(addr_out) && $stable(mirror_q)
                 && mask_q == $past(addr_in)));

    p_retx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (retx && !ld_stb && !cnt_clr) |=> addr_out == $past(mirror_q));

    p_step_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && !at_top)
            |=> ((addr_out & ~mask_q) == $past(addr_out & ~mask_q)));

    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && at_top && !wrap_reload)
            |=> ((addr_out & mask_q) == ALL_ZERO
                 && (addr_out & ~mask_q) == $past(addr_out & ~mask_q)));

    p_wrap_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && at_top && wrap_reload)
            |=> addr_out == $past(mirror_q));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_stb && !cnt_en && !cnt_clr && !retx) |=> $stable(addr_out));

endmodule

// File: tb/test_burst_addr_counter.sv
module test_burst_addr_counter;

    localparam int AW = 18;
    localparam int WATCHDOG_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic          ld_stb, cnt_en, cnt_clr, msk_sel, wrap_reload, retx;
    logic [AW-1:0] addr_out;
    logic          cnt_irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    int    m_cnt, m_mask, m_mir;
    bit    m_irq;
    string m_tag;

    always #2 clk = ~clk;

    burst_addr_counter #(.ADDR_W(AW)) i_burst_addr_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_in     (addr_in),
        .ld_stb      (ld_stb),
        .cnt_en      (cnt_en),
        .cnt_clr     (cnt_clr),
        .msk_sel     (msk_sel),
        .wrap_reload (wrap_reload),
        .retx        (retx),
        .addr_out    (addr_out),
        .cnt_irq_n   (cnt_irq_n)
    );

    // Model update for one edge, from the levels applied before it.
    task automatic model_edge();
        int full;
        full = (1 << AW) - 1;
        if (!rst_n) begin
            m_cnt = 0; m_mask = full; m_mir = 0; m_irq = 0; m_tag = "R1";
        end else if (cnt_clr) begin
            m_cnt = 0; m_mask = full; m_irq = 0; m_tag = "R2";
        end else if (ld_stb) begin
            if (msk_sel) begin m_mask = int'(addr_in); m_tag = "R4"; end
            else begin m_cnt = int'(addr_in); m_mir = int'(addr_in); m_tag = "R3"; end
            m_irq = 0;
        end else if (retx) begin
            m_cnt = m_mir; m_tag = "R5";
        end else if (cnt_en) begin
            int n, f;
            n = 0; f = 0;
            for (int i = 0; i < AW; i++) begin
                if (m_mask[i]) begin
                    if (m_cnt[i]) f |= (1 << n);
                    n++;
                end
            end
            if (f == (1 << n) - 1) begin
                m_irq = 0;
                if (wrap_reload) begin m_cnt = m_mir; m_tag = "R8"; end
                else begin m_cnt = m_cnt & ~m_mask; m_tag = "R7"; end
            end else begin
                int k;
                f = f + 1;
                k = 0;
                for (int i = 0; i < AW; i++) begin
                    if (m_mask[i]) begin
                        m_cnt[i] = f[k];
                        k++;
                    end
                end
                m_irq = (f == (1 << n) - 1);
                m_tag = m_irq ? "R9" : "R6";
            end
        end else begin
            m_tag = "R10";
        end
    endtask

    task automatic compare();
        checks++;
        if (int'(addr_out) != m_cnt) begin
            errors++;
            $display("FAIL %s addr_out actual %05h expected %05h", m_tag, addr_out, m_cnt[AW-1:0]);
        end
        checks++;
        if (cnt_irq_n !== !m_irq) begin
            errors++;
            $display("FAIL %s cnt_irq_n actual %0b expected %0b", m_tag, cnt_irq_n, !m_irq);
        end
    endtask

    // One clock: check the outputs at the falling edge, apply, then take the edge.
    task automatic cyc(input bit r, input bit ld, input bit en, input bit clr,
                       input bit ms, input bit wr, input bit rt, input int a);
        @(negedge clk);
        compare();
        rst_n = r; ld_stb = ld; cnt_en = en; cnt_clr = clr;
        msk_sel = ms; wrap_reload = wr; retx = rt; addr_in = a[AW-1:0];
        @(posedge clk);
        model_edge();
    endtask

    task automatic step_n(input int n, input bit wr);
        for (int i = 0; i < n; i++) cyc(1, 0, 1, 0, 0, wr, 0, 0);
    endtask

    initial begin
        rst_n = 0; ld_stb = 0; cnt_en = 0; cnt_clr = 0;
        msk_sel = 0; wrap_reload = 0; retx = 0; addr_in = '0;
        m_cnt = 0; m_mask = 0; m_mir = 0; m_irq = 0; m_tag = "R1";
        @(posedge clk);
        model_edge();
        // R1: reset held, then released with idle cycles (R10)
        cyc(0, 1, 1, 0, 0, 0, 0, 'h1234);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        // R3 load, then R6 full-width steps
        cyc(1, 1, 0, 0, 0, 0, 0, 'h00010);
        step_n(5, 0);
        // R4 mask to low four bits, start at 0x3000C, step to the top: R9, then R7
        cyc(1, 1, 0, 0, 0, 0, 0, 'h3000C);
        cyc(1, 1, 0, 0, 1, 0, 0, 'h0000F);
        step_n(3, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);          // R10: flag held while idle
        cyc(1, 0, 0, 0, 0, 0, 1, 0);          // R5: retx keeps the flag
        step_n(4, 0);
        step_n(12, 0);
        // R8: terminal step reloads the mirror
        step_n(3, 1);
        step_n(2, 1);
        // scattered mask 0x505 (R6 carry skipping)
        cyc(1, 1, 0, 0, 1, 0, 0, 'h00505);
        cyc(1, 1, 0, 0, 0, 0, 0, 'h2AAAA);
        step_n(9, 0);
        // empty mask: every step terminal (R7, R8)
        cyc(1, 1, 0, 0, 1, 0, 0, 0);
        step_n(2, 0);
        step_n(2, 1);
        // priority cases: clear over load (R2), load over retx, retx over step
        cyc(1, 1, 1, 1, 0, 0, 1, 'h11111);
        cyc(1, 1, 1, 0, 0, 0, 1, 'h22222);
        cyc(1, 0, 1, 0, 0, 0, 1, 0);
        step_n(3, 0);
        // random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int a, sel;
            sel = $urandom_range(0, 3);
            a = (sel == 0) ? int'($urandom_range(0, 15))
              : (sel == 1) ? int'($urandom) & ((1 << AW) - 1)
              : (sel == 2) ? ((1 << $urandom_range(0, 6)) - 1)
              : int'($urandom) & 'h3F;
            cyc(($urandom_range(0, 199) != 0),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) != 0),
                ($urandom_range(0, 49) == 0), $urandom_range(0, 1),
                $urandom_range(0, 1), ($urandom_range(0, 19) == 0), a);
        end
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule